// File: doc/BRIEF.md
# Edge-Serviced Watchdog Supervisor

This block watches a single activity line from a processor. Every change of level on that line, whether rising or falling, counts as a service and restarts an idle timer. If the line stays at one level for a full timeout window, the block reports a fault. The line is first brought into the clock domain through a two-stage synchronizer, so a pulse that does not span a clock edge may go unseen. The timeout and the pulse length are both counted in clock cycles.

A parameter selects one of two ways to report the fault. In level mode, an active-low fault flag drops at timeout and stays low until the next edge on the activity line or until the system reset is asserted. In pulse mode, the timeout raises a reset request for a fixed number of cycles and the fault flag stays high. The request also restarts the timer, so an idle line produces one request per idle window. An asserted system reset always restarts the timer. The watchdog is switched off entirely while the line is marked as floating or while the system runs on backup power.

Top module: `wdt_transition`

## Requirements
- R1: After the asynchronous reset is released, `wdo_n` is 1 and `rst_req` is 0.
- R2: A rising edge and a falling edge on `wdi` both restart the idle timer. A `wdi` that changes level at least once every TIMEOUT_CYC cycles never produces a fault.
- R3: In level mode (MODE = WDT_LEVEL), `wdo_n` goes to 0 once `wdi` has held one level for TIMEOUT_CYC cycles after its synchronized edge. That is TIMEOUT_CYC+2 rising clock edges after the edge that first samples the new level.
- R4: In level mode, a low `wdo_n` returns to 1 on the next synchronized `wdi` edge, or one cycle after `reset_active` is 1.
- R5: While `reset_active` is 1, the idle timer is held at its start. A new window begins only when `reset_active` returns to 0.
- R6: In pulse mode (MODE = WDT_PULSE), a timeout drives `rst_req` to 1 for exactly RST_CYC consecutive cycles, and `wdo_n` stays 1. In level mode, `rst_req` stays 0.
- R7: In pulse mode, a `wdi` that never changes produces repeated `rst_req` pulses. Each new window starts when the previous pulse ends.
- R8: While `wdi_float` or `backup_mode` is 1, the timer is held at zero, `wdo_n` is 1, and no new fault or pulse starts.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wdi | input | 1 | Activity line, asynchronous; either edge services the watchdog |
| reset_active | input | 1 | System reset currently asserted; restarts the timer |
| backup_mode | input | 1 | Running on backup power; disables the watchdog |
| wdi_float | input | 1 | Activity line undriven or high-impedance; disables the watchdog |
| wdo_n | output | 1 | Active-low fault flag (level mode); constant 1 in pulse mode |
| rst_req | output | 1 | Reset request pulse (pulse mode); constant 0 in level mode |

## Verification
The bench builds two instances side by side: one in level mode and one in pulse mode, both with TIMEOUT_CYC = 20 and RST_CYC = 6. These short windows let a run of a few hundred cycles reach several full timeouts, several back-to-back reset pulses and the recovery paths. With them, a counter or synchronizer that is off by one cycle shows up as a one-cycle shift against the cycle-exact behavioural model. The same stimulus drives both modes, so the clearing by edges, by `reset_active` and by the two disable inputs is compared for both fault reporting styles.

// File: rtl/wdt_pkg.sv
package wdt_pkg;

  typedef enum logic {
    WDT_LEVEL = 1'b0,
    WDT_PULSE = 1'b1
  } wdt_mode_e;

endpackage

// File: rtl/wdt_edge_sync.sv
module wdt_edge_sync (
  input  logic clk,
  input  logic rst_n,
  input  logic wdi,
  output logic edge_seen
);

  logic meta_q, sync_q, hist_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      sync_q <= 1'b0;
      hist_q <= 1'b0;
    end else begin
      meta_q <= wdi;
      sync_q <= meta_q;
      hist_q <= sync_q;
    end
  end

  assign edge_seen = sync_q ^ hist_q;

endmodule

// File: rtl/wdt_idle_timer.sv
module wdt_idle_timer #(
  parameter int unsigned TIMEOUT_CYC = 61_750_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clear,
  output logic expire
);

  localparam int unsigned CNT_W = (TIMEOUT_CYC > 1) ? $clog2(TIMEOUT_CYC) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(TIMEOUT_CYC - 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    expire = 1'b0;
    cnt_d  = cnt_q + 1'b1;
    if (clear) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      expire = 1'b1;
      cnt_d  = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assert_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= LAST);

  assert_clear_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
    clear |=> (cnt_q == '0));

endmodule

// File: rtl/wdt_pulse_gen.sv
module wdt_pulse_gen #(
  parameter int unsigned RST_CYC = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic trigger,
  output logic pulse
);

  localparam int unsigned PW = (RST_CYC > 1) ? $clog2(RST_CYC) : 1;
  localparam logic [PW-1:0] PLAST = PW'(RST_CYC - 1);

  logic [PW-1:0] pcnt_q, pcnt_d;
  logic          act_q, act_d;

  always_comb begin
    act_d  = act_q;
    pcnt_d = pcnt_q;
    if (act_q) begin
      if (pcnt_q == PLAST) begin
        act_d  = 1'b0;
        pcnt_d = '0;
      end else begin
        pcnt_d = pcnt_q + 1'b1;
      end
    end else if (trigger) begin
      act_d  = 1'b1;
      pcnt_d = '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q  <= 1'b0;
      pcnt_q <= '0;
    end else begin
      act_q  <= act_d;
      pcnt_q <= pcnt_d;
    end
  end

  assign pulse = act_q;

  assert_pulse_count_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pcnt_q <= PLAST);

  assert_pulse_has_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(act_q) |-> $past(trigger));

endmodule

// File: rtl/wdt_transition.sv
module wdt_transition
  import wdt_pkg::*;
#(
  parameter wdt_mode_e   MODE        = WDT_LEVEL,
  parameter int unsigned TIMEOUT_CYC = 61_750_000,
  parameter int unsigned RST_CYC     = 10_000_000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic wdi,
  input  logic reset_active,
  input  logic backup_mode,
  input  logic wdi_float,
  output logic wdo_n,
  output logic rst_req
);

  logic edge_seen, disabled, clear, expire, own_req;

  assign disabled = backup_mode | wdi_float;
  assign clear    = edge_seen | reset_active | disabled | own_req;

  wdt_edge_sync u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .wdi       (wdi),
    .edge_seen (edge_seen)
  );

  wdt_idle_timer #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_timer (
    .clk    (clk),
    .rst_n  (rst_n),
    .clear  (clear),
    .expire (expire)
  );

  generate
    if (MODE == WDT_PULSE) begin : g_pulse
      wdt_pulse_gen #(.RST_CYC(RST_CYC)) u_pulse (
        .clk     (clk),
        .rst_n   (rst_n),
        .trigger (expire),
        .pulse   (own_req)
      );
      assign wdo_n   = 1'b1;
      assign rst_req = own_req;
    end else begin : g_level
      logic flag_q, flag_d;

      always_comb begin
        flag_d = flag_q;
        if (clear)       flag_d = 1'b1;
        else if (expire) flag_d = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) flag_q <= 1'b1;
        else        flag_q <= flag_d;
      end

      assign own_req = 1'b0;
      assign wdo_n   = flag_q;
      assign rst_req = 1'b0;

      assert_sysreset_releases_R4: assert property (@(posedge clk) disable iff (!rst_n)
        reset_active |=> wdo_n);

      assert_disabled_high_R8: assert property (@(posedge clk) disable iff (!rst_n)
        disabled |=> wdo_n);

      assert_level_no_req_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !rst_req);
    end
  endgenerate

endmodule

// File: tb/wdt_transition_tb.sv
module wdt_transition_tb;
  import wdt_pkg::*;

  localparam int T = 20;
  localparam int R = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wdi = 1'b0, reset_active = 1'b0, backup_mode = 1'b0, wdi_float = 1'b0;
  logic wdo_l, req_l, wdo_p, req_p;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  string phase = "R1";

  always #10 clk = ~clk;

  wdt_transition #(.MODE(WDT_LEVEL), .TIMEOUT_CYC(T), .RST_CYC(R)) u_dut (
    .clk(clk), .rst_n(rst_n), .wdi(wdi), .reset_active(reset_active),
    .backup_mode(backup_mode), .wdi_float(wdi_float), .wdo_n(wdo_l), .rst_req(req_l));

  wdt_transition #(.MODE(WDT_PULSE), .TIMEOUT_CYC(T), .RST_CYC(R)) u_dut_p (
    .clk(clk), .rst_n(rst_n), .wdi(wdi), .reset_active(reset_active),
    .backup_mode(backup_mode), .wdi_float(wdi_float), .wdo_n(wdo_p), .rst_req(req_p));

  // behavioural reference: sample history queue, idle counts, fault and pulse state
  bit hist[$];
  int idle_l, idle_p, pleft;
  bit m_wdo, m_req;

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b at cycle %0d", req, what, act, exp, cyc);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      hist = '{0, 0, 0};
      idle_l = 0; idle_p = 0; pleft = 0; m_wdo = 1; m_req = 0;
    end else begin
      bit e, off, cl, cp, xl, xp;
      e   = (hist[1] != hist[2]);
      off = backup_mode || wdi_float;
      cl  = e || reset_active || off;
      cp  = cl || m_req;
      xl  = !cl && (idle_l == T - 1);
      xp  = !cp && (idle_p == T - 1);
      idle_l = (cl || xl) ? 0 : idle_l + 1;
      idle_p = (cp || xp) ? 0 : idle_p + 1;
      if (cl) m_wdo = 1; else if (xl) m_wdo = 0;
      if (m_req) begin
        pleft--;
        if (pleft == 0) m_req = 0;
      end else if (xp) begin
        m_req = 1; pleft = R;
      end
      hist.push_front(wdi);
      void'(hist.pop_back());
    end
  end

  always @(negedge clk) begin
    if (rst_n && cyc > 0) begin
      check(phase, wdo_l, m_wdo, "level wdo_n");
      check("R6", req_l, 1'b0, "level rst_req");
      check("R6", wdo_p, 1'b1, "pulse wdo_n");
      check(phase, req_p, m_req, "pulse rst_req");
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  int run, rises;
  bit stay;

  initial begin
    idle(3);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", wdo_l, 1'b1, "wdo_n after reset");
    check("R1", req_p, 1'b0, "rst_req after reset");

    phase = "R2";
    for (int i = 0; i < 12; i++) begin
      wdi = ~wdi;
      idle(15);
    end
    check("R2", wdo_l, 1'b1, "no fault under activity");

    phase = "R3";
    wdi = ~wdi;
    idle(T + 3);
    check("R3", wdo_l, 1'b0, "fault after idle window");

    phase = "R4";
    wdi = ~wdi;
    idle(4);
    check("R4", wdo_l, 1'b1, "edge releases fault");
    idle(T + 4);
    reset_active = 1'b1;
    idle(1);
    reset_active = 1'b0;
    check("R4", wdo_l, 1'b1, "system reset releases fault");

    phase = "R5";
    reset_active = 1'b1;
    idle(40);
    reset_active = 1'b0;
    idle(T - 2);
    check("R5", wdo_l, 1'b1, "window restarts after reset_active");
    idle(8);

    phase = "R7";
    wdi = ~wdi;
    run = 0; rises = 0;
    for (int i = 0; i < 150; i++) begin
      @(negedge clk);
      if (req_p) run++;
      else if (run != 0) begin
        rises++;
        check("R6", run == R, 1'b1, "pulse length");
        run = 0;
      end
    end
    check("R7", rises >= 4, 1'b1, "repeated pulses on idle line");

    phase = "R8";
    idle(R + 2);
    wdi_float = 1'b1;
    stay = 1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (i > 0 && (wdo_l !== 1'b1 || req_p !== 1'b0)) stay = 0;
    end
    check("R8", stay, 1'b1, "float disables watchdog");
    wdi_float = 1'b0;
    backup_mode = 1'b1;
    stay = 1;
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (wdo_l !== 1'b1 || req_p !== 1'b0) stay = 0;
    end
    check("R8", stay, 1'b1, "backup disables watchdog");
    backup_mode = 1'b0;
    idle(T + 4);
    check("R8", wdo_l, 1'b0, "watchdog resumes after enable");

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule